// File: doc/BRIEF.md
# Security Event Rate Limiter

This block slows down anyone who tries to drive protected operations, such as signing with an internal key, at full speed. Other logic in the chip raises one-cycle strobes for three kinds of security event: a failed decryption or integrity check, a use of a private key held inside the device, and a detected inconsistency in system behaviour. These events feed a saturating counter. A free-running period timer drains the counter by one step at the end of every period. This happens whether or not anything else is going on.

A protected operation is requested by holding a level request. The block grants it only while the counter reads zero. A grant itself adds one to the counter, so the next grant must wait for at least one period end. Over any long run this allows at most one operation per period. A behaviour-inconsistency event is never tolerated. It sets the counter straight to its maximum, and the device then stays throttled until the counter has drained all the way back down. The period is a parameter counted in system clock cycles. The default is 5 s at 200 MHz, which is well inside a ±5 % window.

Top module: `sec_event_rate_limiter`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, `sec_count_o` is 0, `op_grant_o` is 0 and `idle_o` is 1.
- R2: Each cycle with `ev_decrypt_fail_i` high adds one to the counter, and each cycle with `ev_key_use_i` high adds one. Both high in the same cycle add two. The counter never rises above 2^CNT_W−1.
- R3: A cycle with `ev_suspicious_i` high sets the counter to 2^CNT_W−1 at the next edge. This overrides every other event, grant or drain in that cycle.
- R4: The period timer runs freely from reset and wraps every PERIOD_TICKS cycles. Events and grants never restart it. At each wrap the counter drops by one if it is nonzero, and it never goes below 0.
- R5: If `op_req_i` is high, the counter is 0 and no suspicious event is present in a cycle, then `op_grant_o` is high for exactly the following cycle. That grant adds one to the counter at the same edge.
- R6: Increments and a drain that fall on the same edge combine: next = min(count + increments − drain, 2^CNT_W−1).
- R7: A request held while the counter is nonzero is not lost. It is granted in the cycle after the counter is first seen at zero, provided no suspicious event is present in that cycle.
- R8: Between any two grants there is at least one period wrap. With a request held continuously for more than 500 operations, the number of grants never exceeds 1 + elapsed cycles / PERIOD_TICKS.
- R9: `idle_o` is high exactly when `sec_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_decrypt_fail_i | input | 1 | Strobe: decryption or integrity check failed |
| ev_key_use_i | input | 1 | Strobe: internal private key was used |
| ev_suspicious_i | input | 1 | Strobe: inconsistent system behaviour detected |
| op_req_i | input | 1 | Level request for a protected operation, held until granted |
| op_grant_o | output | 1 | One-cycle grant for the pending request |
| sec_count_o | output | CNT_W | Current security event counter value |
| idle_o | output | 1 | High while the counter is zero |

## Verification
The hardest interaction is a period wrap landing on the same edge as counter increments, either from events or from a grant taken at zero. In that case the drain and the additions must net out correctly and must not saturate early. A suspicious event that coincides with a request at zero is a second collision: it must block the grant and still force the maximum. Both cases are provoked by random strobes whose density is high enough to hit every timer phase, and by directed cycles that place the events on the wrap edge. A bench model, stepped once per cycle from the requirements, predicts the count, grant and idle value for every cycle.

// File: rtl/srl_pkg.sv
package srl_pkg;
    // number of counter increments arriving on one edge (0..3)
    typedef logic [1:0] bump_t;
endpackage

// File: rtl/srl_period_timer.sv
module srl_period_timer #(
    parameter int unsigned PERIOD_TICKS = 1_000_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned TMR_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(PERIOD_TICKS - 1);

    typedef struct packed {
        logic [TMR_W-1:0] phase;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.phase == LAST);
endmodule

// File: rtl/srl_level_counter.sv
module srl_level_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  srl_pkg::bump_t    bump_i,
    input  logic              drain_i,
    input  logic              force_max_i,
    output logic [CNT_W-1:0]  level_o
);
    localparam int unsigned   SUM_W = CNT_W + 2;
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [SUM_W-1:0] TOP_W = {2'b00, TOP};

    typedef struct packed {
        logic [CNT_W-1:0] level;
    } lvl_t;

    lvl_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = SUM_W'(st_q.level) + SUM_W'(bump_i);
        if (drain_i && (st_q.level != '0)) begin
            sum = sum - 1'b1;
        end
        if (force_max_i) begin
            st_d.level = TOP;
        end else if (sum > TOP_W) begin
            st_d.level = TOP;
        end else begin
            st_d.level = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/sec_event_rate_limiter.sv
module sec_event_rate_limiter #(
    parameter int unsigned CNT_W        = 4,
    parameter int unsigned PERIOD_TICKS = 1_000_000_000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ev_decrypt_fail_i,
    input  logic             ev_key_use_i,
    input  logic             ev_suspicious_i,
    input  logic             op_req_i,
    output logic             op_grant_o,
    output logic [CNT_W-1:0] sec_count_o,
    output logic             idle_o
);
    typedef struct packed {
        logic grant;
    } gate_t;

    gate_t           gate_d, gate_q;
    logic            period_tick;
    logic [CNT_W-1:0] level;
    srl_pkg::bump_t  bump;

    srl_period_timer #(
        .PERIOD_TICKS (PERIOD_TICKS)
    ) timer_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (period_tick)
    );

    srl_level_counter #(
        .CNT_W (CNT_W)
    ) level_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bump_i      (bump),
        .drain_i     (period_tick),
        .force_max_i (ev_suspicious_i),
        .level_o     (level)
    );

    always_comb begin
        gate_d       = gate_q;
        gate_d.grant = op_req_i && (level == '0) && !ev_suspicious_i;
        bump         = {1'b0, ev_decrypt_fail_i} + {1'b0, ev_key_use_i}
                     + {1'b0, gate_d.grant};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign op_grant_o  = gate_q.grant;
    assign sec_count_o = level;
    assign idle_o      = (level == '0);
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ev_suspicious_i,
    input logic             op_grant_i,
    input logic [CNT_W-1:0] count_i,
    input logic             tick_i
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic wrap_seen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wrap_seen_q <= 1'b1;
        end else if (op_grant_i) begin
            wrap_seen_q <= tick_i;
        end else begin
            wrap_seen_q <= wrap_seen_q | tick_i;
        end
    end

    p_susp_saturates_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_suspicious_i |=> (count_i == TOP));

    p_grant_from_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_grant_i |-> ($past(count_i) == '0));

    p_grant_counts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_grant_i |-> (count_i != '0));

    p_single_step_drain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i < $past(count_i)) |-> (count_i == $past(count_i) - 1'b1));

    p_wrap_between_grants_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_grant_i |-> wrap_seen_q);
endmodule

bind sec_event_rate_limiter srl_checker #(.CNT_W(CNT_W)) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ev_suspicious_i (ev_suspicious_i),
    .op_grant_i      (op_grant_o),
    .count_i         (sec_count_o),
    .tick_i          (period_tick)
);

// File: tb/sec_event_rate_limiter_tb.sv
module sec_event_rate_limiter_tb_top;
    localparam int CW  = 3;
    localparam int PER = 16;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_s = 1'b0, key_s = 1'b0, sus_s = 1'b0, req = 1'b0;
    logic grant, idle;
    logic [CW-1:0] cnt;

    int total = 0, bad = 0;
    int m_cnt = 0, m_tmr = 0, m_grant = 0;
    bit pend = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sec_event_rate_limiter #(.CNT_W(CW), .PERIOD_TICKS(PER)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ev_decrypt_fail_i(dec_s), .ev_key_use_i(key_s), .ev_suspicious_i(sus_s),
        .op_req_i(req), .op_grant_o(grant), .sec_count_o(cnt), .idle_o(idle));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_count(int c, int d, int k, int s, int g, int tk);
        int n;
        if (s != 0) return MAXV;
        n = c + d + k + g - ((tk != 0 && c > 0) ? 1 : 0);
        return (n > MAXV) ? MAXV : n;
    endfunction

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input string tag, input bit d, input bit k, input bit s, input bit want);
        int g, tk;
        if (want) pend = 1'b1;
        dec_s = d; key_s = k; sus_s = s; req = pend;
        tk = (m_tmr == PER - 1) ? 1 : 0;
        g  = (pend && m_cnt == 0 && !s) ? 1 : 0;
        m_cnt   = next_count(m_cnt, d, k, s, g, tk);
        m_grant = g;
        m_tmr   = (tk != 0) ? 0 : m_tmr + 1;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " count"}, int'(cnt), m_cnt);
        chk("R5 R7 grant", int'(grant), m_grant);
        chk("R9 idle", int'(idle), (m_cnt == 0) ? 1 : 0);
        if (grant) pend = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int grants, cycles;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 count in reset", int'(cnt), 0);
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 idle in reset", int'(idle), 1);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 count after release", int'(cnt), 0);
        chk("R1 grant after release", int'(grant), 0);
        m_tmr = 1;

        // R2 saturation: both strobes together, then repeated
        for (int i = 0; i < 6; i++) step("R2 R6 saturate", 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 at max", int'(cnt), MAXV);
        // R4 drain all the way down with a held request (R7)
        step("R7 hold", 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < PER * (MAXV + 2); i++) step("R4 R7 drain", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 request served", int'(pend), 0);

        // R3 suspicious collides with a request at zero
        while (m_cnt != 0) step("R4 settle", 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3 block grant", 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R3 forced max", int'(cnt), MAXV);
        chk("R3 grant blocked", int'(grant), 0);

        // R6 events placed on the wrap edge
        while (m_cnt != 0) step("R4 settle", 1'b0, 1'b0, 1'b0, 1'b0);
        step("R6 bump", 1'b1, 1'b0, 1'b0, 1'b0);
        while (m_tmr != PER - 1) step("R6 align", 1'b0, 1'b0, 1'b0, 1'b0);
        step("R6 wrap+two", 1'b1, 1'b1, 1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step("R2 R3 R4 R6 random", (r % 11) == 0, (r % 13) == 0, r == 57,
                 $urandom_range(0, 3) == 0);
        end

        // R8 long run: request always held, no events
        while (m_cnt != 0) step("R4 settle", 1'b0, 1'b0, 1'b0, 1'b0);
        grants = 0; cycles = 0;
        while (grants < 505) begin
            step("R8 long run", 1'b0, 1'b0, 1'b0, 1'b1);
            cycles++;
            if (grant) grants++;
            if (cycles > PER * 600) break;
        end
        chk("R8 enough grants", (grants >= 500) ? 1 : 0, 1);
        chk("R8 rate bound", (grants <= 1 + cycles / PER) ? 1 : 0, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule